// File: doc/BRIEF.md
# Configuration Phase Sequencer

This block is the control state machine that brings a configurable device from power-up, or from a reprogram request, to normal operation. It moves through four phases in a fixed order: it clears the configuration memory, initializes, loads the configuration data and starts up. It controls the two shared open-drain handshake lines. For the initialization flag line it has a pull-down enable (`init_drive_low`) and a sensed level (`init_in`). For the completion flag line it has a pull-down enable (`done_drive_low`) and a sensed level (`done_in`). It also latches the mode-select pins and releases the device's I/Os, global write enable and global reset in a fixed order.

The serial data path and the integrity check are outside this block. They report to it through `load_done` and `crc_err`. Any device on a shared line can hold that line low, which stretches the handshake. A sync option makes the block wait after it releases its own completion pull-down, until the shared completion line reads high. Devices chained on one data source can then all leave configuration in the same cycle.

States: CLEAR (memory walk), INIT_WAIT (flag released, wait for the line), LOAD (data phase), CRC_FAIL (error hold), SU_DONE (completion released), SU_SYNC (wait for the shared completion line), SU_IO (I/Os on), SU_GWE (write enable on), SU_GSR (reset released), RUN (operational). The transitions are: CLEAR→INIT_WAIT at the end of a pass with `prog_n` high; CLEAR→CLEAR for another pass while `prog_n` is low; INIT_WAIT→LOAD when `init_in` is high; LOAD→CRC_FAIL on `crc_err`; LOAD→SU_DONE on `load_done`; SU_DONE→SU_SYNC or SU_IO depending on `sync_to_done`; SU_SYNC→SU_IO on `done_in`; SU_IO→SU_GWE→SU_GSR→RUN one cycle each; any state other than CLEAR →CLEAR on `prog_n` low.

Top module: `cfg_phase_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the block is in CLEAR. In that state `init_drive_low`=1, `done_drive_low`=1, `gsr`=1, `io_enable`=0, `gwe`=0, `operational`=0, `load_active`=0, `clr_addr`=0 and `mode_latched`=0.
- R2: `prog_n` low in any state other than CLEAR puts the block in CLEAR on the next cycle with `clr_addr`=0.
- R3: In CLEAR, `clr_we`=1, `init_drive_low`=1, `done_drive_low`=1 and `io_enable`=0. `clr_we` is 0 in every other state.
- R4: In CLEAR, `clr_addr` rises by one each cycle from 0 to CLR_DEPTH-1. At CLR_DEPTH-1 the block checks `prog_n`. If `prog_n` is low, a new pass starts at 0. If it is high, the block enters INIT_WAIT. A low `prog_n` in the middle of a pass does not restart the walk.
- R5: In INIT_WAIT, `init_drive_low`=0 and `done_drive_low`=1. The block stays in INIT_WAIT for as long as `init_in` reads low.
- R6: In the INIT_WAIT cycle where `init_in` first reads high, `mode_pins` is captured into `mode_latched`, and LOAD (`load_active`=1) begins on the next cycle. `mode_latched` does not change at any other time except reset.
- R7: `crc_err` in LOAD moves the block to CRC_FAIL on the next cycle, even when `load_done` is high in the same cycle. CRC_FAIL drives `init_drive_low`=1, keeps `done_drive_low`=1 and ignores `load_done` until `prog_n` goes low.
- R8: When `load_done` is high in LOAD and `crc_err` is low, start-up follows one cycle per step, and each release stays in effect. First `done_drive_low` goes to 0, then `io_enable` goes to 1, then `gwe` goes to 1, then `gsr` goes to 0.
- R9: If `sync_to_done` is 1 in the cycle where the completion pull-down is released, the block pauses with `io_enable`=0 for as long as `done_in` reads low. The I/O step begins on the cycle after `done_in` reads high.
- R10: `operational` goes to 1 on the cycle after the reset-release step. It stays at 1 until `prog_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| prog_n | input | 1 | Reprogram request, active low |
| init_in | input | 1 | Sensed level of the shared initialization flag line |
| init_drive_low | output | 1 | Pull-down enable for the initialization flag line |
| done_in | input | 1 | Sensed level of the shared completion line |
| done_drive_low | output | 1 | Pull-down enable for the completion line |
| mode_pins | input | MODE_W | Mode-select pins |
| mode_latched | output | MODE_W | Mode value captured at the end of initialization |
| sync_to_done | input | 1 | Start-up option: wait for the shared completion line |
| load_done | input | 1 | Data path reports that the load is complete |
| crc_err | input | 1 | Data path reports an integrity-check failure |
| load_active | output | 1 | High during the data load phase |
| clr_we | output | 1 | Memory clear write strobe |
| clr_addr | output | AW | Address being cleared |
| io_enable | output | 1 | Enables the non-configuration I/Os |
| gwe | output | 1 | Global write enable |
| gsr | output | 1 | Global reset, active high |
| operational | output | 1 | Device is in normal operation |

## Verification
Two functions can fall in the same cycle: an integrity failure can be reported in the cycle the data path declares the load complete. The bench raises `crc_err` and `load_done` together in one LOAD cycle. The cycle-level model requires the error to take priority, so the next cycle must show CRC_FAIL with the initialization flag pulled low and no start-up step. A later lone `load_done` must then leave every output unchanged. The bench also drops `prog_n` during a clear pass and during RUN, to separate the end-of-pass check from the check that applies in any other state.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [3:0] {
        PH_CLEAR,
        PH_INIT_WAIT,
        PH_LOAD,
        PH_CRC_FAIL,
        PH_SU_DONE,
        PH_SU_SYNC,
        PH_SU_IO,
        PH_SU_GWE,
        PH_SU_GSR,
        PH_RUN
    } cfg_phase_e;

    typedef struct packed {
        logic init_low;
        logic done_low;
        logic io_en;
        logic wr_en;
        logic rst_hold;
        logic load_act;
        logic oper;
        logic clr_wr;
    } cfg_ctl_t;

endpackage

// File: rtl/cfg_clear_walker.sv
module cfg_clear_walker #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [AW-1:0] addr,
    output logic          pass_end
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign pass_end = run && (addr == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (!run || pass_end) begin
            addr <= '0;
        end else begin
            addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_mode_capture.sv
module cfg_mode_capture #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] pins,
    output logic [W-1:0] held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (capture) begin
            held <= pins;
        end
    end

endmodule

// File: rtl/cfg_phase_seq.sv
module cfg_phase_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLR_DEPTH = 16,
    parameter int MODE_W    = 3,
    localparam int AW       = (CLR_DEPTH > 1) ? $clog2(CLR_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_n,
    input  logic              init_in,
    output logic              init_drive_low,
    input  logic              done_in,
    output logic              done_drive_low,
    input  logic [MODE_W-1:0] mode_pins,
    output logic [MODE_W-1:0] mode_latched,
    input  logic              sync_to_done,
    input  logic              load_done,
    input  logic              crc_err,
    output logic              load_active,
    output logic              clr_we,
    output logic [AW-1:0]     clr_addr,
    output logic              io_enable,
    output logic              gwe,
    output logic              gsr,
    output logic              operational
);

    cfg_phase_e st;
    cfg_phase_e st_nxt;
    cfg_ctl_t   ctl;
    logic       pass_end;
    logic       in_clear;
    logic       take_mode;

    assign in_clear  = (st == PH_CLEAR);
    assign take_mode = (st == PH_INIT_WAIT) && init_in && prog_n;

    cfg_clear_walker #(
        .DEPTH (CLR_DEPTH),
        .AW    (AW)
    ) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (in_clear),
        .addr     (clr_addr),
        .pass_end (pass_end)
    );

    cfg_mode_capture #(
        .W (MODE_W)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (take_mode),
        .pins    (mode_pins),
        .held    (mode_latched)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= PH_CLEAR;
        end else begin
            st <= st_nxt;
        end
    end

    // transitions
    always_comb begin
        st_nxt = st;
        if (!prog_n && !in_clear) begin
            st_nxt = PH_CLEAR;
        end else begin
            unique case (st)
                PH_CLEAR:     if (pass_end && prog_n) st_nxt = PH_INIT_WAIT;
                PH_INIT_WAIT: if (init_in) st_nxt = PH_LOAD;
                PH_LOAD: begin
                    if (crc_err)        st_nxt = PH_CRC_FAIL;
                    else if (load_done) st_nxt = PH_SU_DONE;
                end
                PH_CRC_FAIL:  st_nxt = PH_CRC_FAIL;
                PH_SU_DONE:   st_nxt = sync_to_done ? PH_SU_SYNC : PH_SU_IO;
                PH_SU_SYNC:   if (done_in) st_nxt = PH_SU_IO;
                PH_SU_IO:     st_nxt = PH_SU_GWE;
                PH_SU_GWE:    st_nxt = PH_SU_GSR;
                PH_SU_GSR:    st_nxt = PH_RUN;
                PH_RUN:       st_nxt = PH_RUN;
                default:      st_nxt = PH_CLEAR;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        ctl = '{init_low: 1'b0, done_low: 1'b1, io_en: 1'b0, wr_en: 1'b0,
                rst_hold: 1'b1, load_act: 1'b0, oper: 1'b0, clr_wr: 1'b0};
        unique case (st)
            PH_CLEAR: begin
                ctl.init_low = 1'b1;
                ctl.clr_wr   = 1'b1;
            end
            PH_INIT_WAIT: ;
            PH_LOAD:      ctl.load_act = 1'b1;
            PH_CRC_FAIL:  ctl.init_low = 1'b1;
            PH_SU_DONE,
            PH_SU_SYNC:   ctl.done_low = 1'b0;
            PH_SU_IO: begin
                ctl.done_low = 1'b0;
                ctl.io_en    = 1'b1;
            end
            PH_SU_GWE: begin
                ctl.done_low = 1'b0;
                ctl.io_en    = 1'b1;
                ctl.wr_en    = 1'b1;
            end
            PH_SU_GSR: begin
                ctl.done_low = 1'b0;
                ctl.io_en    = 1'b1;
                ctl.wr_en    = 1'b1;
                ctl.rst_hold = 1'b0;
            end
            PH_RUN: begin
                ctl.done_low = 1'b0;
                ctl.io_en    = 1'b1;
                ctl.wr_en    = 1'b1;
                ctl.rst_hold = 1'b0;
                ctl.oper     = 1'b1;
            end
            default: ctl.init_low = 1'b1;
        endcase
    end

    assign init_drive_low = ctl.init_low;
    assign done_drive_low = ctl.done_low;
    assign io_enable      = ctl.io_en;
    assign gwe            = ctl.wr_en;
    assign gsr            = ctl.rst_hold;
    assign load_active    = ctl.load_act;
    assign operational    = ctl.oper;
    assign clr_we         = ctl.clr_wr;

endmodule

// File: rtl/cfg_phase_seq_chk.sv
module cfg_phase_seq_chk #(
    parameter int CLR_DEPTH = 16,
    parameter int MODE_W    = 3,
    localparam int AW       = (CLR_DEPTH > 1) ? $clog2(CLR_DEPTH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_n,
    input logic              crc_err,
    input logic              init_drive_low,
    input logic              done_drive_low,
    input logic [MODE_W-1:0] mode_pins,
    input logic [MODE_W-1:0] mode_latched,
    input logic              load_active,
    input logic              clr_we,
    input logic [AW-1:0]     clr_addr,
    input logic              io_enable,
    input logic              gwe,
    input logic              gsr,
    input logic              operational
);

    localparam logic [AW-1:0] LAST = AW'(CLR_DEPTH - 1);

    a_r2_prog_to_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_n && !clr_we) |=> (clr_we && clr_addr == '0));

    a_r3_clear_holds_lines: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |-> (init_drive_low && done_drive_low && !io_enable));

    a_r4_addr_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_addr != LAST) |=> (clr_we && clr_addr == AW'($past(clr_addr) + 1'b1)));

    a_r6_mode_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_active) |-> (mode_latched == $past(mode_pins)));

    a_r7_crc_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (load_active && crc_err && prog_n) |=> (init_drive_low && done_drive_low && !load_active));

    a_r8_io_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        io_enable |-> !done_drive_low);

    a_r8_gwe_after_io: assert property (@(posedge clk) disable iff (!rst_n)
        gwe |-> io_enable);

    a_r8_gsr_after_gwe: assert property (@(posedge clk) disable iff (!rst_n)
        !gsr |-> gwe);

    a_r10_oper_last: assert property (@(posedge clk) disable iff (!rst_n)
        operational |-> (!gsr && gwe && io_enable));

endmodule

bind cfg_phase_seq cfg_phase_seq_chk #(
    .CLR_DEPTH (CLR_DEPTH),
    .MODE_W    (MODE_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .prog_n         (prog_n),
    .crc_err        (crc_err),
    .init_drive_low (init_drive_low),
    .done_drive_low (done_drive_low),
    .mode_pins      (mode_pins),
    .mode_latched   (mode_latched),
    .load_active    (load_active),
    .clr_we         (clr_we),
    .clr_addr       (clr_addr),
    .io_enable      (io_enable),
    .gwe            (gwe),
    .gsr            (gsr),
    .operational    (operational)
);

// File: tb/cfg_phase_seq_test.sv
`timescale 1ns/1ps
module cfg_phase_seq_test;

    localparam int D  = 6;
    localparam int MW = 3;
    localparam int AW = $clog2(D);

    // model phase codes
    localparam int M_CLR = 0, M_IW = 1, M_LD = 2, M_FL = 3, M_SD = 4,
                   M_SS = 5, M_IO = 6, M_WE = 7, M_GR = 8, M_RN = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0, prog_n = 1'b1, init_in = 1'b0, done_in = 1'b0;
    logic sync_to_done = 1'b0, load_done = 1'b0, crc_err = 1'b0;
    logic [MW-1:0] mode_pins = '0;
    logic init_drive_low, done_drive_low, load_active, clr_we;
    logic io_enable, gwe, gsr, operational;
    logic [MW-1:0] mode_latched;
    logic [AW-1:0] clr_addr;

    int checks = 0, errors = 0;
    int m_st = M_CLR, m_cnt = 0, m_mode = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cfg_phase_seq #(.CLR_DEPTH(D), .MODE_W(MW)) uut (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .init_in(init_in),
        .init_drive_low(init_drive_low), .done_in(done_in),
        .done_drive_low(done_drive_low), .mode_pins(mode_pins),
        .mode_latched(mode_latched), .sync_to_done(sync_to_done),
        .load_done(load_done), .crc_err(crc_err), .load_active(load_active),
        .clr_we(clr_we), .clr_addr(clr_addr), .io_enable(io_enable),
        .gwe(gwe), .gsr(gsr), .operational(operational));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // one clock: compare against model, advance model, let the design advance
    task automatic cycle();
        int n_st, n_cnt, n_mode;
        @(negedge clk);
        chk("R3 clr_we",         int'(clr_we),         int'(m_st == M_CLR));
        chk("R4 clr_addr",       int'(clr_addr),       m_cnt);
        chk("R5 init_drive_low", int'(init_drive_low), int'(m_st == M_CLR || m_st == M_FL));
        chk("R8 done_drive_low", int'(done_drive_low), int'(m_st < M_SD));
        chk("R6 load_active",    int'(load_active),    int'(m_st == M_LD));
        chk("R6 mode_latched",   int'(mode_latched),   m_mode);
        chk("R8 io_enable",      int'(io_enable),      int'(m_st >= M_IO));
        chk("R8 gwe",            int'(gwe),            int'(m_st >= M_WE));
        chk("R8 gsr",            int'(gsr),            int'(m_st < M_GR));
        chk("R10 operational",   int'(operational),    int'(m_st == M_RN));
        n_st = m_st; n_mode = m_mode;
        n_cnt = (m_st == M_CLR && m_cnt < D - 1) ? m_cnt + 1 : 0;
        if (!rst_n) begin
            n_st = M_CLR; n_cnt = 0; n_mode = 0;
        end else if (!prog_n && m_st != M_CLR) begin
            n_st = M_CLR;
        end else begin
            case (m_st)
                M_CLR: if (m_cnt == D - 1 && prog_n) n_st = M_IW;
                M_IW:  if (init_in) begin n_st = M_LD; n_mode = int'(mode_pins); end
                M_LD:  if (crc_err) n_st = M_FL; else if (load_done) n_st = M_SD;
                M_SD:  n_st = sync_to_done ? M_SS : M_IO;
                M_SS:  if (done_in) n_st = M_IO;
                M_IO, M_WE, M_GR: n_st = m_st + 1;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        m_st = n_st; m_cnt = n_cnt; m_mode = n_mode;
    endtask

    task automatic run_to(input int target);
        for (int i = 0; i < 100 && m_st != target; i++) cycle();
    endtask

    initial begin
        for (int i = 0; i < 3; i++) cycle();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset lines", {init_drive_low, done_drive_low, gsr, io_enable, gwe,
                               operational, load_active}, 7'b1110000);
        chk("R1 reset addr", int'(clr_addr), 0);
        chk("R1 reset mode", int'(mode_latched), 0);

        // first pass, then init held low externally (R5)
        run_to(M_IW);
        for (int i = 0; i < 4; i++) cycle();
        chk("R5 held in init wait", int'(load_active), 0);
        mode_pins = 3'd5; init_in = 1'b1;
        cycle();
        mode_pins = 3'd2;            // must not be re-captured (R6)
        for (int i = 0; i < 3; i++) cycle();
        chk("R6 mode kept", int'(mode_latched), 5);
        load_done = 1'b1; done_in = 1'b1;
        cycle();
        load_done = 1'b0;
        run_to(M_RN);
        for (int i = 0; i < 3; i++) cycle();
        chk("R10 operational", int'(operational), 1);

        // reprogram from RUN, held low over two passes (R2, R4)
        prog_n = 1'b0;
        cycle();
        chk("R2 back to clear", {int'(clr_we), int'(clr_addr)} , {1, 0});
        for (int i = 0; i < 2 * D; i++) cycle();
        chk("R4 still clearing", int'(clr_we), 1);
        prog_n = 1'b1;
        run_to(M_LD);

        // error and completion together (R7)
        crc_err = 1'b1; load_done = 1'b1;
        cycle();
        crc_err = 1'b0; load_done = 1'b0;
        chk("R7 fail state", {int'(init_drive_low), int'(load_active), int'(done_drive_low)},
            {1, 0, 1});
        load_done = 1'b1;
        cycle();
        load_done = 1'b0;
        for (int i = 0; i < 2; i++) cycle();
        chk("R7 load_done ignored", int'(done_drive_low), 1);

        // reprogram, then sync-to-completion start-up (R9)
        prog_n = 1'b0; cycle(); prog_n = 1'b1;
        sync_to_done = 1'b1; done_in = 1'b0;
        run_to(M_LD);
        load_done = 1'b1; cycle(); load_done = 1'b0;
        for (int i = 0; i < 5; i++) cycle();
        chk("R9 paused", {int'(io_enable), int'(done_drive_low)}, {0, 0});
        done_in = 1'b1;
        for (int i = 0; i < 6; i++) cycle();
        chk("R9 resumed to run", int'(operational), 1);

        // reprogram mid-pass is not a restart (R4), prog in init wait (R2)
        prog_n = 1'b0; cycle(); cycle(); cycle(); prog_n = 1'b1;
        run_to(M_IW);
        init_in = 1'b1; prog_n = 1'b0; cycle(); prog_n = 1'b1;
        chk("R2 prog wins over init", int'(clr_we), 1);
        for (int i = 0; i < 3; i++) cycle();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule